// File: doc/BRIEF.md
# Record Slot Identifier Map

This block keeps one identifier word per storage slot in a small synchronous RAM, together with a count of the slots that currently hold a valid identifier. A controller that manages fixed-size record slots asks the map four kinds of question through a single request/response port. It can locate the slot that holds a given identifier, find the lowest free slot, write or erase one slot's entry, and walk the stored identifiers one at a time with a persistent cursor.

The lowest `FIRST_IDX` slots are reserved for bookkeeping elsewhere and are never scanned or reported by a search. An entry of zero means the slot is free. The all-ones value means "none / end of list" and is never stored. Searches are sequential: the engine fetches one slot from the RAM, tests it, and moves on, so latency grows with the scan distance. After reset the engine sweeps the RAM to zero before it accepts its first request.

Top module: `slot_id_map`

## Requirements
- R1: While `rst` is high and for `NUM_SLOTS` cycles after it falls, `req_ready` is low and every entry is being zeroed; after that `req_ready` is high, `rec_count` is 0 and every slot reads as free.
- R2: A lookup (`req_op` = 0) scans from slot `FIRST_IDX` upward and, on the first entry equal to `req_id`, responds with `resp_found` = 1 and that slot in `resp_slot`; the response comes 2·(k+1) cycles after acceptance, where k is the number of slots passed before the match.
- R3: A lookup for identifier 0, or any lookup while `rec_count` is 0, responds in the acceptance cycle with `resp_found` = 0 and `resp_slot` = 0; every unsuccessful lookup reports slot 0.
- R4: A lookup stops without a match as soon as the number of non-zero entries it has examined equals `rec_count`, or at the last slot, whichever comes first.
- R5: Find-empty (`req_op` = 1) returns the lowest slot at or above `FIRST_IDX` whose entry is 0, or `resp_found` = 0 and slot 0 when every such slot is occupied.
- R6: A set (`req_op` = 2) stores `req_id` into `req_slot`, responds two cycles after acceptance with the previous entry in `resp_id`, and raises `rec_count` by one when a non-zero value goes into a free slot; replacing a non-zero entry leaves `rec_count` unchanged.
- R7: A set with `req_id` = 0 erases the slot; erasing an occupied slot lowers `rec_count` by one, erasing a free slot changes nothing.
- R8: A set whose `req_slot` is `NUM_SLOTS` or more, or whose `req_id` is all ones, is ignored: it responds in the acceptance cycle with `resp_found` = 0 and changes no entry and no count.
- R9: Get-next (`req_op` = 3) starts at `FIRST_IDX` when `req_first` is 1 and at the stored cursor otherwise, returns the next non-zero entry in `resp_id` with its slot and `resp_found` = 1, and moves the cursor to one slot past it.
- R10: When get-next finds nothing before the end, or `rec_count` is 0, it returns all ones in `resp_id` with `resp_found` = 0 and puts the cursor back at `FIRST_IDX`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted on a rising edge where `req_ready` is high |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_op | input | 2 | 0 lookup, 1 find-empty, 2 set, 3 get-next |
| req_id | input | ID_W | Identifier to look up or to store |
| req_slot | input | clog2(NUM_SLOTS)+1 | Slot written by a set |
| req_first | input | 1 | Get-next restarts from the first record slot |
| resp_valid | output | 1 | One-cycle pulse carrying the result |
| resp_found | output | 1 | Match, free slot, applied set or valid next entry |
| resp_slot | output | clog2(NUM_SLOTS)+1 | Slot index of the result, 0 when none |
| resp_id | output | ID_W | Next identifier (get-next) or previous entry (set) |
| rec_count | output | clog2(NUM_SLOTS)+1 | Number of valid entries |

## Verification
Every result has a fixed due cycle: immediate answers (identifier 0, empty map, ignored set, iterator at the end) arrive in the edge that accepts the request, a set arrives two edges later, and a scan arrives 2·(k+1) edges after acceptance for k slots passed. The bench counts edges from the accepting edge to the first sample where `resp_valid` is high, compares that count with the figure computed from these rules, and reads the result fields and `rec_count` in that same sample between edges. The early-stop case is checked by latency as well as by result, since a full scan would give the same answer later.

// File: rtl/slotmap_pkg.sv
package slotmap_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_EMPTY  = 2'd1,
    OP_SET    = 2'd2,
    OP_NEXT   = 2'd3
  } map_op_e;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_IDLE,
    ST_READ,
    ST_TEST
  } scan_st_e;

endpackage

// File: rtl/slot_ram.sv
module slot_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto a simple dual-port block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rec_counter.sv
module rec_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && !dec) begin
      count <= count + W'(1);
    end else if (dec && !inc) begin
      count <= count - W'(1);
    end
  end

endmodule

// File: rtl/slot_id_map.sv
module slot_id_map
  import slotmap_pkg::*;
#(
  parameter int ID_W      = 64,
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_op,
  input  logic [ID_W-1:0]              req_id,
  input  logic [$clog2(NUM_SLOTS):0]   req_slot,
  input  logic                         req_first,
  output logic                         resp_valid,
  output logic                         resp_found,
  output logic [$clog2(NUM_SLOTS):0]   resp_slot,
  output logic [ID_W-1:0]              resp_id,
  output logic [$clog2(NUM_SLOTS):0]   rec_count
);

  localparam int AW = $clog2(NUM_SLOTS);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0]   FIRST_P = PW'(FIRST_IDX);
  localparam logic [PW-1:0]   LAST_P  = PW'(NUM_SLOTS - 1);
  localparam logic [PW-1:0]   NSL_P   = PW'(NUM_SLOTS);
  localparam logic [ID_W-1:0] END_ID  = '1;

  scan_st_e        state;
  map_op_e         op_q;
  map_op_e         req_op_e;
  logic [PW-1:0]   ptr;
  logic [PW-1:0]   slot_q;
  logic [PW-1:0]   seen;
  logic [PW-1:0]   seen_nxt;
  logic [PW-1:0]   iter;
  logic [PW-1:0]   start_ix;
  logic [ID_W-1:0] id_q;

  logic            ram_we;
  logic [AW-1:0]   ram_waddr;
  logic [ID_W-1:0] ram_wdata;
  logic [ID_W-1:0] ram_q;

  logic            rd_nz;
  logic            at_last;
  logic            set_wr;
  logic            cnt_inc;
  logic            cnt_dec;

  assign req_op_e  = map_op_e'(req_op);
  assign req_ready = (state == ST_IDLE);
  assign start_ix  = req_first ? FIRST_P : iter;
  assign rd_nz     = (ram_q != '0);
  assign at_last   = (ptr == LAST_P);
  assign seen_nxt  = seen + PW'(rd_nz);

  // The only write besides the reset sweep is a set, in its test cycle.
  assign set_wr    = (state == ST_TEST) && (op_q == OP_SET);
  assign cnt_inc   = set_wr && !rd_nz && (id_q != '0);
  assign cnt_dec   = set_wr && rd_nz && (id_q == '0);

  always_comb begin
    if (state == ST_INIT) begin
      ram_we    = 1'b1;
      ram_waddr = ptr[AW-1:0];
      ram_wdata = '0;
    end else begin
      ram_we    = set_wr;
      ram_waddr = slot_q[AW-1:0];
      ram_wdata = id_q;
    end
  end

  slot_ram #(
    .DEPTH (NUM_SLOTS),
    .W     (ID_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ptr[AW-1:0]),
    .rdata (ram_q)
  );

  rec_counter #(
    .W (PW)
  ) u_count (
    .clk   (clk),
    .rst   (rst),
    .inc   (cnt_inc),
    .dec   (cnt_dec),
    .count (rec_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_INIT;
      op_q       <= OP_LOOKUP;
      ptr        <= '0;
      slot_q     <= '0;
      seen       <= '0;
      iter       <= FIRST_P;
      id_q       <= '0;
      resp_valid <= 1'b0;
      resp_found <= 1'b0;
      resp_slot  <= '0;
      resp_id    <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_INIT: begin
          ptr <= ptr + PW'(1);
          if (ptr == LAST_P) begin
            ptr   <= '0;
            state <= ST_IDLE;
          end
        end

        ST_IDLE: begin
          if (req_valid) begin
            op_q   <= req_op_e;
            id_q   <= req_id;
            slot_q <= req_slot;
            seen   <= '0;
            unique case (req_op_e)
              OP_LOOKUP: begin
                if (req_id == '0 || rec_count == '0) begin
                  resp_valid <= 1'b1;
                  resp_found <= 1'b0;
                  resp_slot  <= '0;
                  resp_id    <= '0;
                end else begin
                  ptr   <= FIRST_P;
                  state <= ST_READ;
                end
              end
              OP_EMPTY: begin
                ptr   <= FIRST_P;
                state <= ST_READ;
              end
              OP_SET: begin
                if (req_slot >= NSL_P || req_id == END_ID) begin
                  resp_valid <= 1'b1;
                  resp_found <= 1'b0;
                  resp_slot  <= req_slot;
                  resp_id    <= '0;
                end else begin
                  ptr   <= req_slot;
                  state <= ST_READ;
                end
              end
              OP_NEXT: begin
                if (rec_count == '0 || start_ix >= NSL_P) begin
                  resp_valid <= 1'b1;
                  resp_found <= 1'b0;
                  resp_slot  <= '0;
                  resp_id    <= END_ID;
                  iter       <= FIRST_P;
                end else begin
                  ptr   <= start_ix;
                  state <= ST_READ;
                end
              end
              default: ;
            endcase
          end
        end

        ST_READ: begin
          state <= ST_TEST;
        end

        ST_TEST: begin
          unique case (op_q)
            OP_LOOKUP: begin
              if (ram_q == id_q) begin
                resp_valid <= 1'b1;
                resp_found <= 1'b1;
                resp_slot  <= ptr;
                resp_id    <= ram_q;
                state      <= ST_IDLE;
              end else if (seen_nxt >= rec_count || at_last) begin
                resp_valid <= 1'b1;
                resp_found <= 1'b0;
                resp_slot  <= '0;
                resp_id    <= '0;
                state      <= ST_IDLE;
              end else begin
                seen  <= seen_nxt;
                ptr   <= ptr + PW'(1);
                state <= ST_READ;
              end
            end
            OP_EMPTY: begin
              if (!rd_nz) begin
                resp_valid <= 1'b1;
                resp_found <= 1'b1;
                resp_slot  <= ptr;
                resp_id    <= '0;
                state      <= ST_IDLE;
              end else if (at_last) begin
                resp_valid <= 1'b1;
                resp_found <= 1'b0;
                resp_slot  <= '0;
                resp_id    <= '0;
                state      <= ST_IDLE;
              end else begin
                ptr   <= ptr + PW'(1);
                state <= ST_READ;
              end
            end
            OP_SET: begin
              resp_valid <= 1'b1;
              resp_found <= 1'b1;
              resp_slot  <= slot_q;
              resp_id    <= ram_q;
              state      <= ST_IDLE;
            end
            OP_NEXT: begin
              if (rd_nz) begin
                resp_valid <= 1'b1;
                resp_found <= 1'b1;
                resp_slot  <= ptr;
                resp_id    <= ram_q;
                iter       <= ptr + PW'(1);
                state      <= ST_IDLE;
              end else if (at_last) begin
                resp_valid <= 1'b1;
                resp_found <= 1'b0;
                resp_slot  <= '0;
                resp_id    <= END_ID;
                iter       <= FIRST_P;
                state      <= ST_IDLE;
              end else begin
                ptr   <= ptr + PW'(1);
                state <= ST_READ;
              end
            end
            default: ;
          endcase
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/slotmap_chk.sv
module slotmap_chk #(
  parameter int ID_W      = 64,
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 2,
  localparam int PW       = $clog2(NUM_SLOTS) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_found,
  input logic [PW-1:0]   resp_slot,
  input logic [ID_W-1:0] resp_id,
  input logic [PW-1:0]   rec_count,
  input logic [1:0]      op_q
);

  // R6: the count never exceeds the number of slots
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
    rec_count <= PW'(NUM_SLOTS));

  // R6 / R7: the count only moves together with a response
  a_r6_count_quiet: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> $stable(rec_count));

  // R2 / R5: a found lookup or free slot is never a reserved slot
  a_r5_slot_floor: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_found && (op_q == 2'd0 || op_q == 2'd1))
      |-> (resp_slot >= PW'(FIRST_IDX) && resp_slot < PW'(NUM_SLOTS)));

  // R3: an unsuccessful lookup reports slot 0
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_found && op_q == 2'd0) |-> resp_slot == '0);

  // R9: a reported next identifier is neither free nor the end marker
  a_r9_next_valid: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_found && op_q == 2'd3)
      |-> (resp_id != '0 && resp_id != '1));

  // R10: an exhausted get-next returns the end marker
  a_r10_next_end: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_found && op_q == 2'd3) |-> resp_id == '1);

  // R1: a response is only ever delivered after the reset sweep ended
  a_r1_resp_idle: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

endmodule

bind slot_id_map slotmap_chk #(
  .ID_W      (ID_W),
  .NUM_SLOTS (NUM_SLOTS),
  .FIRST_IDX (FIRST_IDX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_found (resp_found),
  .resp_slot  (resp_slot),
  .resp_id    (resp_id),
  .rec_count  (rec_count),
  .op_q       (op_q)
);

// File: tb/tb_slot_id_map.sv
module tb_slot_id_map;

  localparam int ID_W      = 64;
  localparam int NUM_SLOTS = 16;
  localparam int FIRST_IDX = 2;
  localparam int PW        = $clog2(NUM_SLOTS) + 1;
  localparam logic [ID_W-1:0] END_ID = '1;

  localparam logic [63:0] ID_A  = 64'h1111_0000_0000_00A1;
  localparam logic [63:0] ID_B  = 64'h2222_0000_0000_00B2;
  localparam logic [63:0] ID_B2 = 64'h2222_0000_0000_0B22;
  localparam logic [63:0] ID_C  = 64'h3333_0000_0000_00C3;
  localparam logic [63:0] ID_D  = 64'h4444_0000_0000_00D4;
  localparam logic [63:0] ID_X  = 64'h5555_0000_0000_00E5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      req_op = 2'd0;
  logic [ID_W-1:0] req_id = '0;
  logic [PW-1:0]   req_slot = '0;
  logic            req_first = 1'b0;
  logic            resp_valid;
  logic            resp_found;
  logic [PW-1:0]   resp_slot;
  logic [ID_W-1:0] resp_id;
  logic [PW-1:0]   rec_count;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic            g_found;
  logic [PW-1:0]   g_slot;
  logic [ID_W-1:0] g_id;
  int              g_lat;

  always #2.5 clk = ~clk;

  slot_id_map #(
    .ID_W      (ID_W),
    .NUM_SLOTS (NUM_SLOTS),
    .FIRST_IDX (FIRST_IDX)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_id     (req_id),
    .req_slot   (req_slot),
    .req_first  (req_first),
    .resp_valid (resp_valid),
    .resp_found (resp_found),
    .resp_slot  (resp_slot),
    .resp_id    (resp_id),
    .rec_count  (rec_count)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one request; g_lat counts edges from the accepting edge to the response.
  task automatic issue(input logic [1:0] op, input logic [63:0] id,
                       input int slot, input logic first);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_id    = id;
    req_slot  = PW'(slot);
    req_first = first;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g_lat = 0;
    while (!resp_valid && g_lat < 200) begin
      @(negedge clk);
      g_lat++;
    end
    g_found = resp_found;
    g_slot  = resp_slot;
    g_id    = resp_id;
  endtask

  function automatic int scan_lat(input int passed);
    return 2 * (passed + 1);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready low in reset", 64'(req_ready), 64'd0);
    chk("R1 count zero in reset", 64'(rec_count), 64'd0);
    rst = 1'b0;
    repeat (NUM_SLOTS - 1) @(negedge clk);
    chk("R1 ready low during sweep", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R1 ready after sweep", 64'(req_ready), 64'd1);
    chk("R1 count zero after sweep", 64'(rec_count), 64'd0);
  endtask

  task automatic t_empty_map();
    issue(2'd0, ID_A, 0, 1'b0);
    chk("R3 lookup on empty map found", 64'(g_found), 64'd0);
    chk("R3 lookup on empty map slot", 64'(g_slot), 64'd0);
    chk("R3 lookup on empty map latency", 64'(g_lat), 64'd0);
    issue(2'd1, '0, 0, 1'b0);
    chk("R5 free slot on empty map", 64'(g_slot), 64'(FIRST_IDX));
    chk("R5 free slot latency", 64'(g_lat), 64'(scan_lat(0)));
    issue(2'd3, '0, 0, 1'b1);
    chk("R10 next on empty map id", g_id, END_ID);
    chk("R10 next on empty map latency", 64'(g_lat), 64'd0);
  endtask

  task automatic t_populate();
    issue(2'd2, ID_A, 2, 1'b0);
    chk("R6 set A applied", 64'(g_found), 64'd1);
    chk("R6 set A old entry", g_id, 64'd0);
    chk("R6 set latency", 64'(g_lat), 64'd2);
    chk("R6 count after A", 64'(rec_count), 64'd1);
    issue(2'd2, ID_B, 5, 1'b0);
    issue(2'd2, ID_C, 9, 1'b0);
    chk("R6 count after three", 64'(rec_count), 64'd3);
  endtask

  task automatic t_lookup();
    issue(2'd0, ID_C, 0, 1'b0);
    chk("R2 lookup C slot", 64'(g_slot), 64'd9);
    chk("R2 lookup C found", 64'(g_found), 64'd1);
    chk("R2 lookup C latency", 64'(g_lat), 64'(scan_lat(9 - FIRST_IDX)));
    issue(2'd0, '0, 0, 1'b0);
    chk("R3 lookup zero id found", 64'(g_found), 64'd0);
    chk("R3 lookup zero id latency", 64'(g_lat), 64'd0);
    issue(2'd0, ID_D, 0, 1'b0);
    chk("R4 missing id found", 64'(g_found), 64'd0);
    chk("R4 missing id slot", 64'(g_slot), 64'd0);
    chk("R4 early stop latency", 64'(g_lat), 64'(scan_lat(9 - FIRST_IDX)));
    issue(2'd1, '0, 0, 1'b0);
    chk("R5 lowest free slot", 64'(g_slot), 64'd3);
    chk("R5 lowest free latency", 64'(g_lat), 64'(scan_lat(1)));
  endtask

  task automatic t_overwrite();
    issue(2'd2, ID_B2, 5, 1'b0);
    chk("R6 overwrite returns old", g_id, ID_B);
    chk("R6 overwrite keeps count", 64'(rec_count), 64'd3);
  endtask

  task automatic t_iterate();
    issue(2'd3, '0, 0, 1'b1);
    chk("R9 first next id", g_id, ID_A);
    chk("R9 first next slot", 64'(g_slot), 64'd2);
    chk("R9 first next latency", 64'(g_lat), 64'(scan_lat(0)));
    issue(2'd3, '0, 0, 1'b0);
    chk("R9 second next id", g_id, ID_B2);
    chk("R9 second next latency", 64'(g_lat), 64'(scan_lat(2)));
    issue(2'd3, '0, 0, 1'b0);
    chk("R9 third next id", g_id, ID_C);
    chk("R9 third next latency", 64'(g_lat), 64'(scan_lat(3)));
    issue(2'd3, '0, 0, 1'b0);
    chk("R10 exhausted next id", g_id, END_ID);
    chk("R10 exhausted next found", 64'(g_found), 64'd0);
    chk("R10 exhausted latency", 64'(g_lat), 64'(scan_lat(NUM_SLOTS - 11)));
    issue(2'd3, '0, 0, 1'b0);
    chk("R10 cursor wrapped", g_id, ID_A);
    chk("R10 cursor wrapped latency", 64'(g_lat), 64'(scan_lat(0)));
  endtask

  task automatic t_clear();
    issue(2'd2, '0, 5, 1'b0);
    chk("R7 clear returns old", g_id, ID_B2);
    chk("R7 clear lowers count", 64'(rec_count), 64'd2);
    issue(2'd2, '0, 7, 1'b0);
    chk("R7 clear of free slot count", 64'(rec_count), 64'd2);
    issue(2'd0, ID_B2, 0, 1'b0);
    chk("R7 cleared id gone", 64'(g_found), 64'd0);
    chk("R4 stop after two valid", 64'(g_lat), 64'(scan_lat(9 - FIRST_IDX)));
  endtask

  task automatic t_ignored();
    issue(2'd2, ID_X, NUM_SLOTS, 1'b0);
    chk("R8 out of range not applied", 64'(g_found), 64'd0);
    chk("R8 out of range latency", 64'(g_lat), 64'd0);
    chk("R8 out of range count", 64'(rec_count), 64'd2);
    issue(2'd0, ID_X, 0, 1'b0);
    chk("R8 out of range id absent", 64'(g_found), 64'd0);
    issue(2'd2, END_ID, 3, 1'b0);
    chk("R8 end marker not applied", 64'(g_found), 64'd0);
    issue(2'd1, '0, 0, 1'b0);
    chk("R8 slot 3 still free", 64'(g_slot), 64'd3);
    chk("R8 count unchanged", 64'(rec_count), 64'd2);
  endtask

  task automatic t_full();
    for (int s = FIRST_IDX; s < NUM_SLOTS; s++) begin
      if (s != 2 && s != 9) issue(2'd2, 64'h100 + 64'(s), s, 1'b0);
    end
    chk("R6 count when full", 64'(rec_count), 64'(NUM_SLOTS - FIRST_IDX));
    issue(2'd1, '0, 0, 1'b0);
    chk("R5 full map found", 64'(g_found), 64'd0);
    chk("R5 full map slot", 64'(g_slot), 64'd0);
    chk("R5 full map latency", 64'(g_lat), 64'(scan_lat(NUM_SLOTS - 1 - FIRST_IDX)));
    issue(2'd0, 64'h100 + 64'(NUM_SLOTS - 1), 0, 1'b0);
    chk("R2 lookup last slot", 64'(g_slot), 64'(NUM_SLOTS - 1));
    chk("R2 lookup last latency", 64'(g_lat), 64'(scan_lat(NUM_SLOTS - 1 - FIRST_IDX)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_empty_map();
    t_populate();
    t_lookup();
    t_overwrite();
    t_iterate();
    t_clear();
    t_ignored();
    t_full();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule